// File: doc/BRIEF.md
# Floppy Controller Host Handshake Port

This block is the host side of a floppy-style disk controller. The host sees two byte-wide locations. A status location can only be read. A data location carries every command byte, every execution-phase data byte and every result byte. The block steps through three phases: command, execution and result. It uses an internal opcode table to find out how many command bytes and result bytes each command has, and whether the command has an execution phase.

The status byte tells the host whether it may touch the data location and which way the next byte must move. It also shows whether a command is in progress, whether polled (non-DMA) execution is underway, and which drives are still seeking. During execution, data passes through a byte FIFO. The engine-side ports fill or drain this FIFO. A DMA service request is raised against a programmable threshold. Result bytes are taken from an engine-supplied port, indexed by the block.

Top module: `fdc_host_if`

## Requirements
- R1: The status byte is {bit7 ready, bit6 direction (1 = host must read), bit5 polled-execution, bit4 command busy, bits 3:2 zero, bits 1:0 drive 1/drive 0 seeking}. It may be read at any time, and reading it changes no state: a result index or command-byte count is not advanced by a status read.
- R2: After reset the status byte is 0x80, the error flag is 0 and the service request is 0. In the command phase, ready is 1 and direction is 0, whatever the FIFO configuration is, so command bytes are paced one at a time.
- R3: Command busy becomes 1 after the first command byte is accepted. It stays 1 through execution and all result bytes except the last, and returns to 0 after the last result byte is read.
- R4: For commands with neither an execution nor a result phase (seek, recalibrate, specify, configure), command busy is 0 in the cycle after the last command byte.
- R5: Opcode bits 4:0 select {command bytes, result bytes, execution}. 0x03 specify {3,0,no}. 0x13 configure {4,0,no}. 0x07 recalibrate {2,0,no}. 0x0F seek {3,0,no}. 0x08 sense-interrupt {1,2,no}. 0x06 read {9,7,yes, disk-to-host}. 0x05 write {9,7,yes, host-to-disk}. Any other code {1,1,no}. Bits 7:5 are ignored.
- R6: In the result phase, ready and direction are 1. A data-location read returns the engine's result byte for the output index, and the index counts 0 up to the result length minus 1.
- R7: Bit 0 of the third specify byte set to 1 selects polled mode. In polled mode the polled-execution flag is 1 only during execution, ready during execution means a byte can move, and the service request stays 0.
- R8: After reset the FIFO is disabled and holds a single byte. Bit 4 of the third configure byte enables the 16-byte FIFO, and bits 3:0 hold the threshold minus 1.
- R9: In DMA mode during execution, the service request is 1 when the fill level (disk-to-host) or the free space (host-to-disk) is at least the threshold. The threshold is 1 when the FIFO is disabled. A push to a full FIFO is dropped.
- R10: The FIFO is emptied on entry to every execution phase, so bytes left from an earlier command are never delivered.
- R11: The last byte of a seek or recalibrate sets the busy bit for the drive named in bit 0 of the second byte. A seek-done pulse clears that drive's bit. Both drives may be busy together. If a set and a clear of the same drive fall in the same cycle, the bit stays set.
- R12: A data-location access that is not permitted is ignored and sets a sticky error flag, cleared only by reset. Not permitted means: a read in the command phase, a write in the result phase, or in execution a wrong-direction access or an access with no byte or no room.
- R13: An exec-done pulse during execution moves the block to the result phase with the result index at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Host access strobe, one cycle per byte |
| we | input | 1 | 1 = host write, 0 = host read |
| addr | input | 1 | 0 = status, 1 = data |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte for the location on addr |
| res_byte | input | 8 | Result byte supplied by the engine for res_idx |
| res_idx | output | 3 | Index of the result byte being offered |
| exec_act | output | 1 | Execution phase in progress |
| eng_wr | input | 1 | Engine pushes a disk byte (disk-to-host) |
| eng_wdata | input | 8 | Byte pushed by the engine |
| eng_rd | input | 1 | Engine pops a host byte (host-to-disk) |
| eng_rdata | output | 8 | Oldest FIFO byte, for the engine |
| exec_done | input | 1 | Execution finished |
| seek_done | input | 2 | Per-drive seek completion pulse |
| dma_req | output | 1 | DMA service request |
| err | output | 1 | Sticky illegal-access flag |

## Verification
A seek-done pulse for a drive can arrive in the same cycle as the final byte of a new seek to that same drive. The bench provokes this by raising seek_done on the strobe of that final byte. It then expects the drive bit still set on the next status read, and cleared only by a later lone pulse. A host pop and an engine push can also coincide during execution. The bench judges that case through the service request and the byte order seen at both ends.

// File: rtl/fdc_host_if.sv
module fdc_host_if #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       we,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] res_byte,
  output logic [2:0] res_idx,
  output logic       exec_act,
  input  logic       eng_wr,
  input  logic [7:0] eng_wdata,
  input  logic       eng_rd,
  output logic [7:0] eng_rdata,
  input  logic       exec_done,
  input  logic [1:0] seek_done,
  output logic       dma_req,
  output logic       err
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  typedef enum logic [1:0] {PH_CMD, PH_EXE, PH_RES} ph_t;

  // {cmd_len[3:0], res_len[2:0], has_exec, disk_to_host}
  function automatic logic [8:0] look(input logic [4:0] op);
    case (op)
      5'h03:   look = {4'd3, 3'd0, 1'b0, 1'b0};
      5'h13:   look = {4'd4, 3'd0, 1'b0, 1'b0};
      5'h07:   look = {4'd2, 3'd0, 1'b0, 1'b0};
      5'h0F:   look = {4'd3, 3'd0, 1'b0, 1'b0};
      5'h08:   look = {4'd1, 3'd2, 1'b0, 1'b0};
      5'h06:   look = {4'd9, 3'd7, 1'b1, 1'b1};
      5'h05:   look = {4'd9, 3'd7, 1'b1, 1'b0};
      default: look = {4'd1, 3'd1, 1'b0, 1'b0};
    endcase
  endfunction

  ph_t           ph;
  logic [3:0]    bcnt;
  logic [4:0]    opc;
  logic          drv, nd, fen;
  logic [AW-1:0] thm1, wp, rp;
  logic [CW-1:0] cnt;
  logic [2:0]    ridx;
  logic [1:0]    dbusy;
  logic [7:0]    mem [DEPTH];

  logic [8:0]    lk, lo;
  logic [CW-1:0] cap, thr, free;
  logic          dir_rd, ready, xreq, rdy, ok, good, last, seeky, enter_exe, push, pop;
  logic [1:0]    set_vec;
  logic [7:0]    stat;

  assign lk     = look(bcnt == 4'd0 ? wdata[4:0] : opc);
  assign lo     = look(opc);
  assign dir_rd = lo[0];
  assign cap    = fen ? CW'(DEPTH) : CW'(1);
  assign thr    = fen ? CW'(thm1) + CW'(1) : CW'(1);
  assign free   = cap - cnt;
  assign ready  = dir_rd ? (cnt != '0) : (cnt < cap);
  assign xreq   = dir_rd ? (cnt >= thr) : (free >= thr);

  assign rdy  = (ph == PH_CMD) || (ph == PH_RES) || (ph == PH_EXE && nd && ready);
  assign stat = {rdy, (ph == PH_RES) || (ph == PH_EXE && dir_rd), (ph == PH_EXE) && nd,
                 (ph != PH_CMD) || (bcnt != 4'd0), 2'b00, dbusy};

  always_comb begin
    case (ph)
      PH_CMD:  ok = we;
      PH_RES:  ok = !we;
      PH_EXE:  ok = ready && (we != dir_rd);
      default: ok = 1'b0;
    endcase
  end

  assign good      = cs && addr && ok;
  assign last      = bcnt == lk[8:5] - 4'd1;
  assign enter_exe = (ph == PH_CMD) && good && last && lk[1];
  assign seeky     = (opc == 5'h07) || (opc == 5'h0F);
  assign set_vec   = ((ph == PH_CMD) && good && last && bcnt != 4'd0 && seeky)
                     ? ((bcnt == 4'd1 ? wdata[0] : drv) ? 2'b10 : 2'b01) : 2'b00;

  assign push = (ph == PH_EXE) && (dir_rd ? eng_wr : good) && (cnt < cap);
  assign pop  = (ph == PH_EXE) && (dir_rd ? good : eng_rd) && (cnt != '0);

  assign rdata     = !addr ? stat : (ph == PH_RES) ? res_byte : (ph == PH_EXE) ? mem[rp] : 8'h00;
  assign eng_rdata = mem[rp];
  assign exec_act  = ph == PH_EXE;
  assign res_idx   = ridx;
  assign dma_req   = (ph == PH_EXE) && !nd && xreq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_CMD; bcnt <= '0; opc <= '0; drv <= 1'b0; nd <= 1'b0;
      fen <= 1'b0; thm1 <= '0; ridx <= '0; err <= 1'b0;
    end else begin
      if (cs && addr && !ok) err <= 1'b1;
      case (ph)
        PH_CMD: if (good) begin
          if (bcnt == 4'd0) opc <= wdata[4:0];
          if (bcnt == 4'd1) drv <= wdata[0];
          if (bcnt == 4'd2 && opc == 5'h03) nd <= wdata[0];
          if (bcnt == 4'd2 && opc == 5'h13) begin
            fen  <= wdata[4];
            thm1 <= wdata[AW-1:0];
          end
          if (last) begin
            bcnt <= '0;
            ridx <= '0;
            if (lk[1]) ph <= PH_EXE;
            else if (lk[4:2] != 3'd0) ph <= PH_RES;
          end else begin
            bcnt <= bcnt + 4'd1;
          end
        end
        PH_EXE: if (exec_done) begin
          ph   <= PH_RES;
          ridx <= '0;
        end
        PH_RES: if (good) begin
          if (ridx == lo[4:2] - 3'd1) ph <= PH_CMD;
          else ridx <= ridx + 3'd1;
        end
        default: ph <= PH_CMD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dbusy <= 2'b00;
    else        dbusy <= (dbusy & ~seek_done) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || enter_exe) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= dir_rd ? eng_wdata : wdata;
  end
endmodule

// File: rtl/fdc_host_if_chk.sv
module fdc_host_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       addr,
  input logic [7:0] stat,
  input logic       exec_act,
  input logic       dma_req,
  input logic       err,
  input logic [1:0] seek_done
);
  p_cmd_pace_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stat[4] |-> (stat[7] && !stat[6]));
  p_busy_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[4]) |-> $past(cs && addr));
  p_exec_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_act |-> stat[4]);
  p_polled_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat[5] |-> exec_act);
  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(exec_act) && stat[6]) |-> !dma_req);
  p_seek_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[0]) |-> $past(seek_done[0]));
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind fdc_host_if fdc_host_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .stat(stat),
  .exec_act(exec_act), .dma_req(dma_req), .err(err), .seek_done(seek_done)
);

// File: tb/sim_fdc_host_if.sv
module sim_fdc_host_if;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, we = 0, addr = 0, eng_wr = 0, eng_rd = 0, exec_done = 0;
  logic [7:0] wdata = 0, eng_wdata = 0, rdata, eng_rdata, res_byte;
  logic [2:0] res_idx;
  logic [1:0] seek_done = 0;
  logic exec_act, dma_req, err;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;
  assign res_byte = 8'hA0 | {5'd0, res_idx};

  fdc_host_if u0 (.*);

  // {opcode, cmd_len, res_len, has_exec}
  localparam logic [15:0] VEC [8] = '{
    {8'h03, 4'd3, 3'd0, 1'b0}, {8'h13, 4'd4, 3'd0, 1'b0},
    {8'h07, 4'd2, 3'd0, 1'b0}, {8'h0F, 4'd3, 3'd0, 1'b0},
    {8'h08, 4'd1, 3'd2, 1'b0}, {8'h46, 4'd9, 3'd7, 1'b1},
    {8'hC5, 4'd9, 3'd7, 1'b1}, {8'h1F, 4'd1, 3'd1, 1'b0}};

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic a, input logic [7:0] d,
                     input logic [1:0] sd, output logic [7:0] q);
    @(negedge clk);
    cs = 1; we = w; addr = a; wdata = d; seek_done = sd;
    #1 q = rdata;
    @(posedge clk);
    #1 cs = 0; we = 0; addr = 0; seek_done = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    logic [7:0] q;
    acc(1'b1, 1'b1, d, 2'b00, q);
  endtask

  task automatic rd(output logic [7:0] q);
    acc(1'b0, 1'b1, 8'h00, 2'b00, q);
  endtask

  task automatic st(output logic [7:0] s);
    addr = 0;
    #1 s = rdata;
  endtask

  task automatic pulse(input int which, input logic [1:0] sd, input logic [7:0] d);
    @(negedge clk);
    if (which == 0) begin eng_wr = 1; eng_wdata = d; end
    if (which == 1) eng_rd = 1;
    if (which == 2) exec_done = 1;
    if (which == 3) seek_done = sd;
    @(posedge clk);
    #1 eng_wr = 0; eng_rd = 0; exec_done = 0; seek_done = 0;
  endtask

  task automatic reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic cmd9(input logic [7:0] op);
    wr(op);
    for (int i = 0; i < 8; i++) wr(8'h00);
  endtask

  task automatic drain_results(input int n);
    logic [7:0] q;
    for (int i = 0; i < n; i++) rd(q);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] s, q;
    reset();
    st(s);
    check("R2 reset status", s, 8'h80);
    check("R2 reset err", {7'd0, err}, 8'h00);
    check("R2 reset dma_req", {7'd0, dma_req}, 8'h00);

    rd(q);
    st(s);
    check("R12 read in command phase sets err", {7'd0, err}, 8'h01);
    check("R12 ignored read keeps status", s, 8'h80);
    wr(8'h08);
    check("R12 err sticky", {7'd0, err}, 8'h01);
    drain_results(2);
    reset();

    for (int v = 0; v < 8; v++) begin
      automatic logic [7:0] op = VEC[v][15:8];
      automatic int cl = int'(VEC[v][7:4]);
      automatic int rl = int'(VEC[v][3:1]);
      automatic logic ex = VEC[v][0];
      for (int b = 0; b < cl; b++) begin
        wr(b == 0 ? op : 8'h00);
        st(s);
        if (b < cl - 1) check("R5 R2 R3 mid-command flags", s & 8'hF0, 8'h90);
        else if (ex) check("R5 exec entry flags", s & 8'hF0, op[4:0] == 5'h06 ? 8'h50 : 8'h10);
        else if (rl != 0) check("R5 R6 result entry flags", s & 8'hF0, 8'hD0);
        else check("R4 busy drops after last byte", s & 8'hF0, 8'h80);
      end
      if (ex) begin
        pulse(2, 2'b00, 8'h00);
        st(s);
        check("R13 exec_done enters results", s & 8'hF0, 8'hD0);
        check("R13 index restarts", {5'd0, res_idx}, 8'h00);
      end
      for (int r = 0; r < rl; r++) begin
        rd(q);
        check("R6 result byte", q, 8'hA0 | 8'(r));
        st(s);
        check("R3 R6 flags after result read", s & 8'hF0, r < rl - 1 ? 8'hD0 : 8'h80);
      end
    end
    check("R12 no error on legal traffic", {7'd0, err}, 8'h00);
    pulse(3, 2'b11, 8'h00);

    wr(8'h03); wr(8'h00); wr(8'h01);
    cmd9(8'h06);
    st(s);
    check("R7 polled exec, empty", s, 8'h70);
    pulse(0, 2'b00, 8'h5A);
    st(s);
    check("R7 polled exec, byte ready", s, 8'hF0);
    check("R7 no service request when polled", {7'd0, dma_req}, 8'h00);
    rd(q);
    check("R7 polled data byte", q, 8'h5A);
    pulse(2, 2'b00, 8'h00);
    st(s);
    check("R7 polled flag gone in results", s, 8'hD0);
    drain_results(7);
    reset();

    cmd9(8'h06);
    pulse(0, 2'b00, 8'h11);
    check("R8 single-byte FIFO requests at 1", {7'd0, dma_req}, 8'h01);
    pulse(0, 2'b00, 8'h22);
    rd(q);
    check("R9 push to full dropped, first byte", q, 8'h11);
    check("R9 request drops when empty", {7'd0, dma_req}, 8'h00);
    check("R12 no error before empty read", {7'd0, err}, 8'h00);
    rd(q);
    check("R12 read of empty FIFO flagged", {7'd0, err}, 8'h01);
    pulse(2, 2'b00, 8'h00);
    drain_results(7);
    reset();

    wr(8'h13); wr(8'h00); wr(8'h13); wr(8'h00);
    cmd9(8'h06);
    for (int i = 0; i < 3; i++) pulse(0, 2'b00, 8'h40 + 8'(i));
    check("R9 below threshold 4", {7'd0, dma_req}, 8'h00);
    pulse(0, 2'b00, 8'h43);
    check("R8 R9 threshold 4 reached", {7'd0, dma_req}, 8'h01);
    pulse(2, 2'b00, 8'h00);
    drain_results(7);
    cmd9(8'h06);
    for (int i = 0; i < 3; i++) pulse(0, 2'b00, 8'h50);
    check("R10 stale bytes flushed", {7'd0, dma_req}, 8'h00);
    pulse(2, 2'b00, 8'h00);
    drain_results(7);

    cmd9(8'h05);
    check("R9 write entry free 16", {7'd0, dma_req}, 8'h01);
    for (int i = 0; i < 12; i++) wr(8'h30 + 8'(i));
    check("R9 free space 4 still requests", {7'd0, dma_req}, 8'h01);
    wr(8'h3C);
    check("R9 free space 3 drops request", {7'd0, dma_req}, 8'h00);
    @(negedge clk); eng_rd = 1;
    #1 check("R9 engine sees oldest byte", eng_rdata, 8'h30);
    @(posedge clk); #1 eng_rd = 0;
    check("R9 pop restores request", {7'd0, dma_req}, 8'h01);
    check("R12 no error on write data", {7'd0, err}, 8'h00);
    pulse(2, 2'b00, 8'h00);
    drain_results(7);

    wr(8'h0F); wr(8'h01); wr(8'h00);
    st(s);
    check("R11 drive 1 seeking", s, 8'h82);
    wr(8'h07); wr(8'h00);
    st(s);
    check("R11 both drives seeking", s, 8'h83);
    pulse(3, 2'b10, 8'h00);
    st(s);
    check("R11 drive 1 done", s, 8'h81);
    wr(8'h0F); wr(8'h00);
    acc(1'b1, 1'b1, 8'h00, 2'b01, q);
    st(s);
    check("R11 set wins over same-cycle done", s, 8'h81);
    pulse(3, 2'b01, 8'h00);
    st(s);
    check("R11 drive 0 done", s, 8'h80);

    wr(8'h08);
    acc(1'b0, 1'b0, 8'h00, 2'b00, q);
    check("R1 status read in result phase", q, 8'hD0);
    acc(1'b0, 1'b0, 8'h00, 2'b00, q);
    rd(q);
    check("R1 status reads leave index", q, 8'hA0);
    rd(q);
    check("R1 second result", q, 8'hA1);
    st(s);
    check("R1 back to command phase", s, 8'h80);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule